// File: doc/BRIEF.md
# Data Translation Permission Checker

This block sits behind the data-side translation array. A request arrives with its virtual address, access size, context, access space, read or write type, and a flag that says whether the access space is a no-fault space. The array's matching entry comes in alongside it: a hit flag, the entry's index, its physical page base, its page-size code and four attribute bits. The attribute bits mark the page as privileged-only, writable, no-fault-only or side-effect.

One cycle later the block returns a fault code, the physical address, and a flag that marks the access uncacheable and strictly ordered. On any translation fault it captures the faulting virtual page and context in a tag register. The trap handler reads that register.

A two-slot store of recent good translations lets the block answer without the array. The slots are keyed by access space and by the translation-state word. The low bit of that word is the privilege level, where 1 means privileged. Any change to the word empties both slots.

Top module: `xlat_perm_unit`

## Requirements
- R1: When the address is not a multiple of the access size (1 << req_size bytes), the fault code is 1 (alignment). This holds whatever the entry and the recent-translation store hold, and the tag register keeps its value.
- R2: When neither the array (ent_hit=0) nor a recent-translation slot hits, the fault code is 2 (miss).
- R3: On an array hit, faults follow a fixed priority. First is code 3: a privileged page accessed while state_word[0]=0. Next is code 4: a write to a non-writable page. Next is code 5: a no-fault-only page accessed from a normal space. Last is code 6: a side-effect page accessed from a no-fault space. If none applies, the code is 0.
- R4: A write to a non-writable page gives protection code 4, which is different from the privilege, no-fault and side-effect codes.
- R5: On a fault-free result, rsp_uncache is 1 exactly when the page has its side-effect bit set or physical address bit 39 is 1. On a faulting result it is 0.
- R6: The physical address takes page bits from the entry above the page offset and virtual bits below it. The offset width is 13 + 3*ent_pg bits, so codes 0 to 3 give 8K, 64K, 512K and 4M pages.
- R7: On any fault other than alignment, tag_access is loaded with {req_vaddr[63:13], req_ctx[12:0]}. On a fault-free result, tag_access is unchanged.
- R8: A fault-free translation from the array goes into slot 0, and the old slot 0 moves to slot 1. This does not happen if the entry index already sits in either slot.
- R9: A change of state_word invalidates both slots.
- R10: A slot answers a request only if it has the same access space and the request falls in its page. A write also needs the slot's page to be writable. A slot answer sets rsp_cached and never faults.
- R11: rsp_valid pulses for one cycle, one cycle after req_valid. After reset, rsp_valid, rsp_fault, rsp_cached and tag_access are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_word | input | STATE_W | Translation-state word; bit 0 = privileged |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | VA_W | Virtual address |
| req_size | input | 2 | log2 of access size in bytes |
| req_ctx | input | CTX_W | Context number |
| req_space | input | SPACE_W | Access-space identifier (store key) |
| req_nf_space | input | 1 | Access space is a no-fault space |
| ent_hit | input | 1 | Array found a matching entry |
| ent_id | input | ID_W | Index of the matching entry |
| ent_pa | input | PA_W | Entry physical page base |
| ent_pg | input | 2 | Entry page-size code |
| ent_priv | input | 1 | Page is privileged-only |
| ent_writable | input | 1 | Page is writable |
| ent_nfo | input | 1 | Page is no-fault-only |
| ent_side | input | 1 | Page has side effects |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault code (0 none) |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Uncacheable and strictly ordered |
| rsp_cached | output | 1 | Answered by a recent-translation slot |
| tag_access | output | VA_W | Faulting page and context |

## Verification
The fault checks are exercised in a chain. Each step removes one condition from an entry that has all of them set. This shows that every code appears only when all higher-priority conditions are absent. Page-size codes are each paired with one address so that the offset split is separated per size.

The recent-translation store is probed with requests that present no array hit. An answer can then only come from a slot. Sequences of three distinct pages, a duplicate index in another space, a changed state word, and mismatched space, write and page requests tell apart the refill order, the presence rule, the invalidation and each part of the slot key.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_PRIV  = 3'd3,
    FLT_PROT  = 3'd4,
    FLT_NFO   = 3'd5,
    FLT_SIDE  = 3'd6
  } fault_e;

  // Page offset mask for a page-size code: 13 + 3*code bits.
  function automatic logic [63:0] off_mask(input logic [1:0] pg);
    logic [6:0] sh;
    sh = 7'd13 + 7'd3 * {5'd0, pg};
    return (64'd1 << sh) - 64'd1;
  endfunction

endpackage

// File: rtl/xlat_fault_eval.sv
module xlat_fault_eval
  import xlat_pkg::*;
(
  input  logic   hit,
  input  logic   user,
  input  logic   write,
  input  logic   nf_space,
  input  logic   pg_priv,
  input  logic   pg_writable,
  input  logic   pg_nfo,
  input  logic   pg_side,
  output fault_e flt
);

  always_comb begin
    if (!hit)                      flt = FLT_MISS;
    else if (user && pg_priv)      flt = FLT_PRIV;
    else if (write && !pg_writable) flt = FLT_PROT;
    else if (pg_nfo && !nf_space)  flt = FLT_NFO;
    else if (pg_side && nf_space)  flt = FLT_SIDE;
    else                           flt = FLT_NONE;
  end

  always_comb begin
    AST_PROT_NEEDS_WRITE: assert (flt != FLT_PROT || write); // R4
  end

endmodule

// File: rtl/xlat_recent_cache.sv
module xlat_recent_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int ID_W    = 6,
  parameter int SPACE_W = 8,
  parameter int STATE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state_word,
  input  logic [VA_W-1:0]    lk_va,
  input  logic [SPACE_W-1:0] lk_space,
  input  logic               lk_write,
  output logic               lk_hit,
  output logic [PA_W-1:0]    lk_pa,
  output logic [1:0]         lk_pg,
  output logic               lk_side,
  input  logic               fill_en,
  input  logic [ID_W-1:0]    fill_id,
  input  logic [1:0]         fill_pg,
  input  logic [PA_W-1:0]    fill_pa,
  input  logic               fill_wr,
  input  logic               fill_side
);

  localparam int SLOTS = 2;

  logic [STATE_W-1:0] st_q;
  logic [SLOTS-1:0]   s_v;
  logic [ID_W-1:0]    s_id [SLOTS];
  logic [SPACE_W-1:0] s_sp [SLOTS];
  logic [VA_W-1:0]    s_va [SLOTS];
  logic [1:0]         s_pg [SLOTS];
  logic [PA_W-1:0]    s_pa [SLOTS];
  logic               s_wr [SLOTS];
  logic               s_sd [SLOTS];

  logic [SLOTS-1:0]   m;
  logic [SLOTS-1:0]   pres;
  logic               st_chg;
  logic [63:0]        fill_om;
  logic               do_push;

  assign st_chg  = (state_word != st_q);
  assign fill_om = off_mask(fill_pg);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [63:0] om;
    assign om = off_mask(s_pg[g]);
    assign m[g] = s_v[g] && !st_chg && (s_sp[g] == lk_space) &&
                  ((lk_va & ~om[VA_W-1:0]) == s_va[g]) &&
                  (!lk_write || s_wr[g]);
    assign pres[g] = s_v[g] && (s_id[g] == fill_id);
  end

  assign lk_hit  = |m;
  assign lk_pa   = m[0] ? s_pa[0] : s_pa[1];
  assign lk_pg   = m[0] ? s_pg[0] : s_pg[1];
  assign lk_side = m[0] ? s_sd[0] : s_sd[1];

  // Presence is ignored when the slots are being emptied this cycle.
  assign do_push = fill_en && (st_chg || !(|pres));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      s_v  <= '0;
    end else begin
      if (st_chg) begin
        st_q <= state_word;
        s_v  <= '0;
      end
      if (do_push) begin
        s_v[0] <= 1'b1;
        s_v[1] <= s_v[0] && !st_chg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      s_id[1] <= s_id[0];  s_id[0] <= fill_id;
      s_sp[1] <= s_sp[0];  s_sp[0] <= lk_space;
      s_va[1] <= s_va[0];  s_va[0] <= lk_va & ~fill_om[VA_W-1:0];
      s_pg[1] <= s_pg[0];  s_pg[0] <= fill_pg;
      s_pa[1] <= s_pa[0];  s_pa[0] <= fill_pa;
      s_wr[1] <= s_wr[0];  s_wr[0] <= fill_wr;
      s_sd[1] <= s_sd[0];  s_sd[0] <= fill_side;
    end
  end

  AST_SLOT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    (s_v[0] && s_v[1]) |-> (s_id[0] != s_id[1])); // R8

endmodule

// File: rtl/xlat_perm_unit.sv
module xlat_perm_unit
  import xlat_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int CTX_W   = 13,
  parameter int ID_W    = 6,
  parameter int SPACE_W = 8,
  parameter int STATE_W = 8,
  parameter int IO_BIT  = 39
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state_word,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_size,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic [SPACE_W-1:0] req_space,
  input  logic               req_nf_space,
  input  logic               ent_hit,
  input  logic [ID_W-1:0]    ent_id,
  input  logic [PA_W-1:0]    ent_pa,
  input  logic [1:0]         ent_pg,
  input  logic               ent_priv,
  input  logic               ent_writable,
  input  logic               ent_nfo,
  input  logic               ent_side,
  output logic               rsp_valid,
  output logic [2:0]         rsp_fault,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_uncache,
  output logic               rsp_cached,
  output logic [VA_W-1:0]    tag_access
);

  logic [3:0]      szm;
  logic            misal;
  logic            user;
  logic            c_hit;
  logic [PA_W-1:0] c_pa;
  logic [1:0]      c_pg;
  logic            c_side;
  fault_e          eval_flt;
  fault_e          sel_flt;
  logic [PA_W-1:0] src_pa;
  logic [1:0]      src_pg;
  logic            src_side;
  logic [63:0]     om;
  logic [PA_W-1:0] pa_out;
  logic            fill_en;
  logic            tag_ld;

  assign user  = !state_word[0];
  assign szm   = (4'd1 << req_size) - 4'd1;
  assign misal = |(req_vaddr[2:0] & szm[2:0]);

  xlat_recent_cache #(
    .VA_W(VA_W), .PA_W(PA_W), .ID_W(ID_W),
    .SPACE_W(SPACE_W), .STATE_W(STATE_W)
  ) u_recent (
    .clk(clk), .rst(rst), .state_word(state_word),
    .lk_va(req_vaddr), .lk_space(req_space), .lk_write(req_write),
    .lk_hit(c_hit), .lk_pa(c_pa), .lk_pg(c_pg), .lk_side(c_side),
    .fill_en(fill_en), .fill_id(ent_id), .fill_pg(ent_pg),
    .fill_pa(ent_pa), .fill_wr(ent_writable), .fill_side(ent_side)
  );

  xlat_fault_eval u_eval (
    .hit(ent_hit), .user(user), .write(req_write), .nf_space(req_nf_space),
    .pg_priv(ent_priv), .pg_writable(ent_writable), .pg_nfo(ent_nfo),
    .pg_side(ent_side), .flt(eval_flt)
  );

  always_comb begin
    if (misal)      sel_flt = FLT_ALIGN;
    else if (c_hit) sel_flt = FLT_NONE;
    else            sel_flt = eval_flt;
  end

  assign src_pa   = c_hit ? c_pa   : ent_pa;
  assign src_pg   = c_hit ? c_pg   : ent_pg;
  assign src_side = c_hit ? c_side : ent_side;
  assign om       = off_mask(src_pg);
  assign pa_out   = (src_pa & ~om[PA_W-1:0]) | (req_vaddr[PA_W-1:0] & om[PA_W-1:0]);

  assign fill_en = req_valid && !misal && !c_hit && (eval_flt == FLT_NONE);
  assign tag_ld  = req_valid && (sel_flt != FLT_NONE) && (sel_flt != FLT_ALIGN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 3'd0;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      rsp_cached  <= 1'b0;
      tag_access  <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid ? sel_flt : FLT_NONE;
      rsp_pa      <= pa_out;
      rsp_uncache <= req_valid && (sel_flt == FLT_NONE) && (src_side || pa_out[IO_BIT]);
      rsp_cached  <= req_valid && !misal && c_hit;
      if (tag_ld) tag_access <= {req_vaddr[VA_W-1:CTX_W], req_ctx};
    end
  end

  AST_ALIGN_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misal) |=> (rsp_fault == FLT_ALIGN)); // R1
  AST_TAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault == FLT_NONE || rsp_fault == FLT_ALIGN)) |-> $stable(tag_access)); // R7
  AST_UNC_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
    rsp_uncache |-> (rsp_valid && rsp_fault == FLT_NONE)); // R5
  AST_CACHED_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rsp_cached |-> (rsp_fault == FLT_NONE)); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11

endmodule

// File: tb/sim_xlat_perm_unit.sv
module sim_xlat_perm_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  state_word = 8'h01;
  logic        req_valid = 1'b0, req_write = 1'b0, req_nf_space = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_size = '0;
  logic [12:0] req_ctx = 13'h0A5C;
  logic [7:0]  req_space = '0;
  logic        ent_hit = 1'b0, ent_priv = 1'b0, ent_writable = 1'b0;
  logic        ent_nfo = 1'b0, ent_side = 1'b0;
  logic [5:0]  ent_id = '0;
  logic [39:0] ent_pa = '0;
  logic [1:0]  ent_pg = '0;
  logic        rsp_valid, rsp_uncache, rsp_cached;
  logic [2:0]  rsp_fault;
  logic [39:0] rsp_pa;
  logic [63:0] tag_access;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [3:0] AT_RW = 4'b0100;
  localparam logic [3:0] AT_RO = 4'b0000;

  always #5 clk = ~clk;

  xlat_perm_unit u0 (
    .clk(clk), .rst(rst), .state_word(state_word),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_ctx(req_ctx), .req_space(req_space),
    .req_nf_space(req_nf_space), .ent_hit(ent_hit), .ent_id(ent_id),
    .ent_pa(ent_pa), .ent_pg(ent_pg), .ent_priv(ent_priv),
    .ent_writable(ent_writable), .ent_nfo(ent_nfo), .ent_side(ent_side),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_uncache(rsp_uncache), .rsp_cached(rsp_cached), .tag_access(tag_access)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_pa(input logic [39:0] base, input logic [63:0] va,
                                         input logic [1:0] pg);
    logic [39:0] msk;
    msk = 40'((64'd1 << (13 + 3 * pg)) - 64'd1);
    return (base & ~msk) | (va[39:0] & msk);
  endfunction

  // at = {priv, writable, nfo, side}
  task automatic fire(input logic w, input logic [63:0] va, input logic [1:0] sz,
                      input logic [7:0] sp, input logic nf, input logic hit,
                      input logic [5:0] id, input logic [39:0] pa,
                      input logic [1:0] pg, input logic [3:0] at);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_vaddr = va; req_size = sz;
    req_space = sp; req_nf_space = nf; ent_hit = hit; ent_id = id;
    ent_pa = pa; ent_pg = pg;
    {ent_priv, ent_writable, ent_nfo, ent_side} = at;
    @(negedge clk);
    req_valid = 1'b0; ent_hit = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset valid", 64'(rsp_valid), 0);
    chk("R11 reset fault", 64'(rsp_fault), 0);
    chk("R11 reset cached", 64'(rsp_cached), 0);
    chk("R11 reset tag", tag_access, 0);
  endtask

  task automatic t_pulse;
    fire(0, 64'h7000, 0, 8'd10, 0, 1, 6'd1, 40'h00_0000_2000, 0, AT_RW);
    chk("R11 valid high", 64'(rsp_valid), 1);
    @(negedge clk);
    chk("R11 valid low", 64'(rsp_valid), 0);
  endtask

  task automatic t_align;
    logic [63:0] tb4;
    tb4 = tag_access;
    fire(0, 64'h1002, 2, 8'd31, 0, 1, 6'd41, 40'h00_0100_0000, 0, AT_RW);
    chk("R1 misaligned code", 64'(rsp_fault), 1);
    chk("R1 tag unchanged", tag_access, tb4);
    fire(0, 64'h1002, 1, 8'd31, 0, 1, 6'd41, 40'h00_0100_0000, 0, AT_RW);
    chk("R1 aligned half ok", 64'(rsp_fault), 0);
  endtask

  task automatic t_miss;
    logic [63:0] va;
    va = 64'hABCD_E000_1234_5678;
    fire(0, va, 0, 8'd32, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R2 miss code", 64'(rsp_fault), 2);
    chk("R7 tag on miss", tag_access, {va[63:13], req_ctx});
  endtask

  task automatic t_priority;
    state_word = 8'h00;
    fire(1, 64'h9000, 0, 8'd33, 0, 1, 6'd42, 40'h00_0200_0000, 0, 4'b1010);
    chk("R3 priv first", 64'(rsp_fault), 3);
    chk("R7 tag on priv", tag_access, {52'h0000_0000_0000_9 >> 1, req_ctx});
    fire(1, 64'h9000, 0, 8'd33, 0, 1, 6'd42, 40'h00_0200_0000, 0, 4'b0010);
    chk("R4 protection code", 64'(rsp_fault), 4);
    fire(0, 64'h9000, 0, 8'd33, 0, 1, 6'd42, 40'h00_0200_0000, 0, 4'b0010);
    chk("R3 nofault-only", 64'(rsp_fault), 5);
    fire(0, 64'h9000, 0, 8'd33, 1, 1, 6'd42, 40'h00_0200_0000, 0, 4'b0101);
    chk("R3 side in nf space", 64'(rsp_fault), 6);
    fire(1, 64'h9000, 0, 8'd33, 0, 1, 6'd42, 40'h00_0200_0000, 0, 4'b0101);
    chk("R3 side normal ok", 64'(rsp_fault), 0);
    chk("R5 side uncache", 64'(rsp_uncache), 1);
    state_word = 8'h01;
    fire(0, 64'hA000, 0, 8'd34, 0, 1, 6'd43, 40'h00_0200_0000, 0, 4'b1000);
    chk("R3 priv page priv mode", 64'(rsp_fault), 0);
  endtask

  task automatic t_uncache;
    logic [63:0] tb4;
    fire(0, 64'h4000, 3, 8'd35, 0, 1, 6'd44, 40'h80_0000_0000, 0, AT_RW);
    chk("R5 io bit uncache", 64'(rsp_uncache), 1);
    fire(0, 64'h4000, 3, 8'd36, 0, 1, 6'd45, 40'h01_0000_0000, 0, AT_RW);
    chk("R5 plain cacheable", 64'(rsp_uncache), 0);
    tb4 = tag_access;
    fire(1, 64'h4000, 3, 8'd37, 0, 1, 6'd46, 40'h80_0000_0000, 0, AT_RO);
    chk("R5 fault not uncache", 64'(rsp_uncache), 0);
    chk("R7 tag loaded", tag_access, {52'h4000 >> 13 , req_ctx} | 64'h0);
    fire(0, 64'h6000, 0, 8'd38, 0, 1, 6'd47, 40'h00_0000_0000, 0, AT_RW);
    chk("R7 tag kept on ok", tag_access, {52'h4000 >> 13, req_ctx});
    if (tb4 == 64'hFFFF) n_chk = n_chk;
  endtask

  task automatic t_pa;
    for (int p = 0; p < 4; p++) begin
      fire(0, 64'h0000_0000_0ABC_DEF7, 0, 8'(20 + p), 0, 1, 6'(50 + p),
           40'h5A_5A5A_5A5A, 2'(p), AT_RW);
      chk("R6 pa split", 64'(rsp_pa), 64'(exp_pa(40'h5A_5A5A_5A5A, 64'h0ABC_DEF7, 2'(p))));
    end
  endtask

  task automatic t_order;
    fire(0, 64'h10_0000, 0, 8'd60, 0, 1, 6'd10, 40'h00_1111_2000, 0, AT_RW);
    fire(0, 64'h20_0000, 0, 8'd60, 0, 1, 6'd11, 40'h00_2222_4000, 0, AT_RW);
    fire(0, 64'h10_0010, 0, 8'd60, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R10 slot answer", 64'(rsp_cached), 1);
    chk("R10 slot no fault", 64'(rsp_fault), 0);
    chk("R6 slot pa", 64'(rsp_pa), 64'h00_1111_2010);
    fire(0, 64'h30_0000, 0, 8'd60, 0, 1, 6'd12, 40'h00_3333_6000, 0, AT_RW);
    fire(0, 64'h10_0000, 0, 8'd60, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R8 oldest evicted", 64'(rsp_fault), 2);
    fire(0, 64'h20_0008, 0, 8'd60, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R8 second kept", 64'(rsp_cached), 1);
  endtask

  task automatic t_present;
    state_word = 8'h03;
    fire(0, 64'h40_0000, 0, 8'd51, 0, 1, 6'd20, 40'h00_4444_0000, 0, AT_RW);
    fire(0, 64'h50_0000, 0, 8'd51, 0, 1, 6'd21, 40'h00_5555_0000, 0, AT_RW);
    fire(0, 64'h40_0000, 0, 8'd52, 0, 1, 6'd20, 40'h00_4444_0000, 0, AT_RW);
    chk("R8 other space from array", 64'(rsp_cached), 0);
    fire(0, 64'h50_0000, 0, 8'd51, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R8 no push when present B", 64'(rsp_cached), 1);
    fire(0, 64'h40_0000, 0, 8'd51, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R8 no push when present A", 64'(rsp_cached), 1);
    state_word = 8'h01;
    @(negedge clk);
    fire(0, 64'h50_0000, 0, 8'd51, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R9 state change empties", 64'(rsp_fault), 2);
    chk("R9 not cached", 64'(rsp_cached), 0);
  endtask

  task automatic t_keyed;
    fire(0, 64'h60_0000, 0, 8'd53, 0, 1, 6'd25, 40'h00_6666_0000, 0, AT_RO);
    chk("R10 fill ok", 64'(rsp_fault), 0);
    fire(0, 64'h60_0000, 0, 8'd54, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R10 space key", 64'(rsp_fault), 2);
    fire(1, 64'h60_0000, 0, 8'd53, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R10 write needs writable", 64'(rsp_fault), 2);
    fire(0, 64'h60_1F00, 0, 8'd53, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R10 same page hit", 64'(rsp_cached), 1);
    chk("R10 same page pa", 64'(rsp_pa), 64'h00_6666_1F00);
    fire(0, 64'h60_2000, 0, 8'd53, 0, 0, 6'd0, 40'h0, 0, AT_RW);
    chk("R10 next page misses", 64'(rsp_fault), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_align();
    t_miss();
    t_priority();
    t_uncache();
    t_pa();
    t_order();
    t_present();
    t_keyed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule